// File: doc/BRIEF.md
# DSP Condition Flag Generator

This block produces the single condition bit that a DSP datapath leaves behind after each ALU or shift operation. The surrounding datapath supplies the operation class, the 40-bit result, the carry or borrow out, the last bit shifted out and the signed-overflow indication of the full-width operation. A 3-bit mode select picks which condition the bit represents. The choices are carry/borrow, negative, zero, overflow, signed greater-or-equal and signed greater-than.

The result is treated as 8 guard bits stacked above a 32-bit register field. Depending on the mode and on whether the operation is arithmetic or logical, the sign, zero and range tests either look at the guard bits or ignore them. The flag is registered. It changes only on cycles where the update strobe is high, so a later conditional instruction can consume it. An error bit marks any update attempted with a reserved mode code.

Top module: `dcf_flag_unit`

## Requirements
- R1: Operation class `op_i` is encoded as follows: 00 arithmetic ALU, 01 logical ALU, 10 arithmetic shift, 11 logical shift. Mode `mode_i` is encoded as follows: 000 carry, 001 negative, 010 zero, 011 overflow, 100 signed greater-than, 101 signed greater-or-equal. `res_i[39:32]` are the guard bits and `res_i[31:0]` is the register field. When `upd_i` is high at a rising clock edge, `flag_o` takes the new value at that edge.
- R2: In carry mode, the flag is set as follows: an arithmetic ALU operation loads `carry_i`; either shift class loads `shout_i`; a logical ALU operation loads 0.
- R3: In negative mode, the flag is set as follows: arithmetic classes load `res_i[39]`; logical classes load `res_i[31]`.
- R4: In zero mode, the flag is set to 1 exactly when the tested bits are all zero. Arithmetic classes test all 40 bits. Logical classes test only `res_i[31:0]`.
- R5: In overflow mode, arithmetic classes load 1 when `res_i[39:31]` are not all equal, meaning the value does not fit the register field. Logical classes load 0.
- R6: In signed greater-or-equal mode, arithmetic classes load NOT(`res_i[39]` XOR `ovf_i`). Logical classes load 0.
- R7: In signed greater-than mode, arithmetic classes load NOT((`res_i[39]` XOR `ovf_i`) OR zero40), where zero40 means all 40 result bits are 0. Logical classes load 0.
- R8: While `upd_i` is low, `flag_o` keeps its value and `err_o` is 0 on the following cycle.
- R9: An update with mode code 110 or 111 leaves `flag_o` unchanged. For that update, `err_o` is 1 for exactly the one cycle following the edge.
- R10: A synchronous active-high `rst` drives `flag_o` and `err_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Update strobe |
| mode_i | input | 3 | Condition mode select |
| op_i | input | 2 | Operation class |
| res_i | input | 40 | Guard bits over the register field |
| carry_i | input | 1 | Carry or borrow out of the ALU |
| shout_i | input | 1 | Last bit shifted out |
| ovf_i | input | 1 | Signed overflow of the full-width operation |
| flag_o | output | 1 | Registered condition flag |
| err_o | output | 1 | Reserved-mode update indication |

## Verification
The flag is the only state, so a wrong internal decision appears at `flag_o` one cycle after the update edge that caused it. If the bad value goes unnoticed, it persists through every later cycle with the strobe low, until the next update overwrites it. The bench pushes each expected flag into a queue and compares it at the cycle after each edge. It concentrates on the boundaries where the guard-bit choice matters: a zero register field with nonzero guard bits, values just inside and just outside the 32-bit range, and guard-bit overflow combined with either sign.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic [1:0] {
    OP_ALU_ARITH   = 2'b00,
    OP_ALU_LOGIC   = 2'b01,
    OP_SHIFT_ARITH = 2'b10,
    OP_SHIFT_LOGIC = 2'b11
  } op_class_e;

  typedef enum logic [2:0] {
    MD_CARRY = 3'b000,
    MD_NEG   = 3'b001,
    MD_ZERO  = 3'b010,
    MD_OVF   = 3'b011,
    MD_GT    = 3'b100,
    MD_GE    = 3'b101,
    MD_RSV0  = 3'b110,
    MD_RSV1  = 3'b111
  } cond_mode_e;

  function automatic logic is_arith(op_class_e op);
    return (op == OP_ALU_ARITH) || (op == OP_SHIFT_ARITH);
  endfunction
endpackage

// File: rtl/dcf_detect.sv
module dcf_detect #(
  parameter int GUARD_W = 8,
  parameter int REG_W   = 32,
  localparam int RES_W  = GUARD_W + REG_W
) (
  input  logic [RES_W-1:0] res,
  output logic             zero_full,
  output logic             zero_reg,
  output logic             sign_full,
  output logic             sign_reg,
  output logic             no_fit
);
  // Bits from the top of the guard field down to the register sign bit.
  logic [GUARD_W:0] top_bits;

  assign top_bits  = res[RES_W-1:REG_W-1];
  assign zero_reg  = ~|res[REG_W-1:0];
  assign zero_full = zero_reg & ~|res[RES_W-1:REG_W];
  assign sign_full = res[RES_W-1];
  assign sign_reg  = res[REG_W-1];
  assign no_fit    = ~((&top_bits) | (~|top_bits));
endmodule

// File: rtl/dcf_rules.sv
module dcf_rules
  import dcf_pkg::*;
(
  input  cond_mode_e mode,
  input  op_class_e  op,
  input  logic       carry,
  input  logic       shout,
  input  logic       ovf,
  input  logic       zero_full,
  input  logic       zero_reg,
  input  logic       sign_full,
  input  logic       sign_reg,
  input  logic       no_fit,
  output logic       flag_nxt,
  output logic       rsv
);
  logic arith;
  logic ge_raw;

  assign arith  = is_arith(op);
  assign ge_raw = ~(sign_full ^ ovf);

  always_comb begin
    flag_nxt = 1'b0;
    rsv      = 1'b0;
    unique case (mode)
      MD_CARRY: begin
        unique case (op)
          OP_ALU_ARITH: flag_nxt = carry;
          OP_ALU_LOGIC: flag_nxt = 1'b0;
          default:      flag_nxt = shout;
        endcase
      end
      MD_NEG:  flag_nxt = arith ? sign_full : sign_reg;
      MD_ZERO: flag_nxt = arith ? zero_full : zero_reg;
      MD_OVF:  flag_nxt = arith & no_fit;
      MD_GE:   flag_nxt = arith & ge_raw;
      MD_GT:   flag_nxt = arith & ge_raw & ~zero_full;
      default: rsv = 1'b1;
    endcase
  end
endmodule

// File: rtl/dcf_flag_unit.sv
module dcf_flag_unit
  import dcf_pkg::*;
#(
  parameter int GUARD_W = 8,
  parameter int REG_W   = 32,
  parameter int MODE_W  = 3,
  parameter int OP_W    = 2,
  localparam int RES_W  = GUARD_W + REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [RES_W-1:0]  res_i,
  input  logic              carry_i,
  input  logic              shout_i,
  input  logic              ovf_i,
  output logic              flag_o,
  output logic              err_o
);
  logic zero_full, zero_reg, sign_full, sign_reg, no_fit;
  logic flag_nxt, rsv;

  dcf_detect #(.GUARD_W(GUARD_W), .REG_W(REG_W)) u_det (
    .res       (res_i),
    .zero_full (zero_full),
    .zero_reg  (zero_reg),
    .sign_full (sign_full),
    .sign_reg  (sign_reg),
    .no_fit    (no_fit)
  );

  dcf_rules u_rules (
    .mode      (cond_mode_e'(mode_i)),
    .op        (op_class_e'(op_i)),
    .carry     (carry_i),
    .shout     (shout_i),
    .ovf       (ovf_i),
    .zero_full (zero_full),
    .zero_reg  (zero_reg),
    .sign_full (sign_full),
    .sign_reg  (sign_reg),
    .no_fit    (no_fit),
    .flag_nxt  (flag_nxt),
    .rsv       (rsv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      err_o <= upd_i & rsv;
      if (upd_i && !rsv) flag_o <= flag_nxt;
    end
  end
endmodule

// File: rtl/dcf_flag_unit_chk.sv
module dcf_flag_unit_chk #(
  parameter int RES_W = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             upd_i,
  input logic [2:0]       mode_i,
  input logic [1:0]       op_i,
  input logic [RES_W-1:0] res_i,
  input logic             flag_o,
  input logic             err_o
);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> ($stable(flag_o) && !err_o));

  a_r9_reserved_hold: assert property (@(posedge clk) disable iff (rst)
    (upd_i && mode_i[2:1] == 2'b11) |=> ($stable(flag_o) && err_o));

  a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
    (upd_i && mode_i[2:1] != 2'b11) |=> !err_o);

  a_r2_logic_clear: assert property (@(posedge clk) disable iff (rst)
    (upd_i && mode_i == 3'b000 && op_i == 2'b01) |=> !flag_o);

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (upd_i && mode_i == 3'b011 && op_i[0]) |=> !flag_o);

  a_r4_zero_set: assert property (@(posedge clk) disable iff (rst)
    (upd_i && mode_i == 3'b010 && res_i == '0) |=> flag_o);

  a_r7_gt_zero: assert property (@(posedge clk) disable iff (rst)
    (upd_i && mode_i == 3'b100 && res_i == '0) |=> !flag_o);

  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!flag_o && !err_o));
endmodule

bind dcf_flag_unit dcf_flag_unit_chk #(.RES_W(RES_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .upd_i  (upd_i),
  .mode_i (mode_i),
  .op_i   (op_i),
  .res_i  (res_i),
  .flag_o (flag_o),
  .err_o  (err_o)
);

// File: tb/dcf_flag_unit_test.sv
module dcf_flag_unit_test;
  localparam int PERIOD = 10;

  typedef struct {
    logic  flag;
    logic  err;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  op_i = '0;
  logic [39:0] res_i = '0;
  logic        carry_i = 1'b0, shout_i = 1'b0, ovf_i = 1'b0;
  logic        flag_o, err_o;

  int   n_vec = 0;
  int   n_bad = 0;
  logic model_flag = 1'b0;
  bit   finished = 0;
  exp_t q[$];

  always #(PERIOD/2) clk = ~clk;

  dcf_flag_unit uut (
    .clk(clk), .rst(rst), .upd_i(upd_i), .mode_i(mode_i), .op_i(op_i),
    .res_i(res_i), .carry_i(carry_i), .shout_i(shout_i), .ovf_i(ovf_i),
    .flag_o(flag_o), .err_o(err_o)
  );

  function automatic logic ref_flag(logic [2:0] m, logic [1:0] op, logic [39:0] r,
                                    logic c, logic s, logic o);
    logic ar, z40;
    ar  = (op == 2'b00) || (op == 2'b10);
    z40 = (r == 40'd0);
    case (m)
      3'd0: return (op == 2'b00) ? c : (op == 2'b01) ? 1'b0 : s;
      3'd1: return ar ? r[39] : r[31];
      3'd2: return ar ? z40 : (r[31:0] == 32'd0);
      3'd3: return ar && !((r[39:31] == 9'h1FF) || (r[39:31] == 9'h000));
      3'd4: return ar && !((r[39] ^ o) || z40);
      3'd5: return ar && !(r[39] ^ o);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(logic u, logic [2:0] m);
    if (!u) return "R8";
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R7";
      3'd5: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic drive(logic u, logic [2:0] m, logic [1:0] op, logic [39:0] r,
                       logic c, logic s, logic o);
    exp_t e;
    @(negedge clk);
    upd_i = u; mode_i = m; op_i = op; res_i = r;
    carry_i = c; shout_i = s; ovf_i = o;
    e.err = u && (m[2:1] == 2'b11);
    if (u && !e.err) model_flag = ref_flag(m, op, r, c, s, o);
    e.flag = model_flag;
    e.tag  = tag_of(u, m);
    q.push_back(e);
  endtask

  // Monitor: compares each queued item just after the capturing edge.
  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (flag_o !== e.flag || err_o !== e.err) begin
        n_bad++;
        $display("FAIL %s: flag/err actual %b/%b expected %b/%b", e.tag,
                 flag_o, err_o, e.flag, e.err);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: set the flag, then reset and check both outputs
    rst = 1'b0;
    drive(1'b1, 3'd2, 2'b00, 40'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    n_vec++;
    if (flag_o !== 1'b0 || err_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: flag/err actual %b/%b expected 0/0", flag_o, err_o);
    end
    model_flag = 1'b0;
    q.delete();
    rst = 1'b0;

    // R2 carry mode across classes
    drive(1, 3'd0, 2'b00, 40'h1, 1, 0, 0);
    drive(1, 3'd0, 2'b01, 40'h1, 1, 1, 0);
    drive(1, 3'd0, 2'b10, 40'h1, 0, 1, 0);
    drive(1, 3'd0, 2'b11, 40'h1, 0, 0, 0);
    drive(1, 3'd0, 2'b11, 40'h1, 0, 1, 0);
    // R3 negative: guard sign vs register sign
    drive(1, 3'd1, 2'b00, 40'h00_8000_0000, 0, 0, 0);
    drive(1, 3'd1, 2'b01, 40'h00_8000_0000, 0, 0, 0);
    drive(1, 3'd1, 2'b10, 40'h80_0000_0000, 0, 0, 0);
    drive(1, 3'd1, 2'b11, 40'h80_0000_0000, 0, 0, 0);
    // R4 zero: guard bits only count for arithmetic
    drive(1, 3'd2, 2'b00, 40'h01_0000_0000, 0, 0, 0);
    drive(1, 3'd2, 2'b01, 40'h01_0000_0000, 0, 0, 0);
    drive(1, 3'd2, 2'b10, 40'h0, 0, 0, 0);
    drive(1, 3'd2, 2'b11, 40'h0, 0, 0, 0);
    // R5 overflow at the 32-bit limit
    drive(1, 3'd3, 2'b00, 40'h00_7FFF_FFFF, 0, 0, 0);
    drive(1, 3'd3, 2'b00, 40'h00_8000_0000, 0, 0, 0);
    drive(1, 3'd3, 2'b10, 40'hFF_8000_0000, 0, 0, 0);
    drive(1, 3'd3, 2'b10, 40'hFF_7FFF_FFFF, 0, 0, 0);
    drive(1, 3'd3, 2'b11, 40'h00_8000_0000, 0, 0, 0);
    // R6 / R7 with guard-bit overflow
    drive(1, 3'd5, 2'b00, 40'h80_0000_0000, 0, 0, 1);
    drive(1, 3'd5, 2'b00, 40'h7F_FFFF_FFFF, 0, 0, 1);
    drive(1, 3'd5, 2'b00, 40'h0, 0, 0, 0);
    drive(1, 3'd5, 2'b01, 40'h1, 0, 0, 0);
    drive(1, 3'd4, 2'b00, 40'h0, 0, 0, 0);
    drive(1, 3'd4, 2'b10, 40'h1, 0, 0, 0);
    drive(1, 3'd4, 2'b00, 40'h80_0000_0000, 0, 0, 1);
    drive(1, 3'd4, 2'b11, 40'h1, 0, 0, 0);
    // R8 idle hold and R9 reserved hold with a set flag
    drive(1, 3'd2, 2'b00, 40'h0, 0, 0, 0);
    drive(0, 3'd3, 2'b01, 40'h5, 0, 0, 0);
    drive(1, 3'd6, 2'b01, 40'h5, 0, 0, 0);
    drive(1, 3'd7, 2'b00, 40'h5, 0, 0, 0);
    drive(0, 3'd7, 2'b00, 40'h5, 0, 0, 0);

    // Random vectors across all modes and classes (R1 through R9)
    for (int i = 0; i < 1500; i++) begin
      logic [39:0] r;
      r = {$urandom, $urandom};
      case ($urandom_range(0, 4))
        0: r = 40'd0;
        1: r[39:31] = {9{r[31]}};
        2: r[31:0] = 32'd0;
        default: ;
      endcase
      drive($urandom_range(0, 7) != 0, 3'($urandom_range(0, 7)),
            2'($urandom_range(0, 3)), r, 1'($urandom), 1'($urandom),
            1'($urandom));
    end
    drive(0, 3'd0, 2'b00, 40'd0, 0, 0, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule